// File: doc/BRIEF.md
# Serial Control Register File

This block holds the configuration of an audio datapath in a bank of 9-bit registers that can only be written. A host byte stream delivers control words two bytes at a time, for example from a two-wire target front end that sits outside this block. Each byte pair is split into a 7-bit register address and a 9-bit value, and that value is written into the addressed register. The whole bank is always visible on a flat parallel output bus, so downstream logic reads its settings directly without a read path.

One address near the top of the map does not hold data. A write to it restores every register to its power-on value. The asynchronous active-low reset also loads those values. The block raises a one-cycle strobe that carries the address after every accepted write, so dependent logic can react to a change. A frame-abort input drops a half-received pair when the bus front end sees a stop or a repeated start in the middle of a word.

Top module: `scrf_top`

## Requirements
- R1: While the active-low reset is low, and after it is released, each register holds its default. The defaults are 0x121 at 0x00, 0x194 at 0x07, 0x0FF at each of 0x14 through 0x19, 0x05E at 0x32, 0x03E at 0x33, and zero everywhere else. Register n occupies bits n*9+8 down to n*9 of `regFlat`.
- R2: The first byte of a pair gives the address in bits 7:1 and data bit 8 in bit 0. The second byte gives data bits 7:0. The addressed register shows the new value in the cycle after the clock edge that samples the second byte.
- R3: Each accepted write or restore raises `wrStrobe` for exactly one cycle, in the same cycle the register changes. `wrAddr` carries the address during that cycle. No strobe appears without an accepted pair.
- R4: A pair whose address is above 0x35 changes no register and raises no strobe.
- R5: A pair addressed to 0x35 puts every register back to its R1 default, whatever its data bits are. It raises the strobe with address 0x35.
- R6: While `frameAbort` is high, a stored first byte is discarded, and any byte offered in the same cycle is dropped. The next valid byte is then taken as a first byte.
- R7: Any number of idle cycles (with `byteValid` low) may separate the two bytes of a pair, or one pair from the next.
- R8: A write changes only the addressed register. When no pair completes, the bank holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; loads the defaults |
| byteValid | input | 1 | `byteData` holds a byte this cycle |
| byteData | input | 8 | Incoming control byte |
| frameAbort | input | 1 | Discards a partial byte pair |
| regFlat | output | 486 | All registers; register n in bits n*9+8:n*9 |
| wrStrobe | output | 1 | One-cycle pulse after an accepted write or restore |
| wrAddr | output | 7 | Address of the most recent accepted write |

## Verification
The hardest case to bring about is a frame abort that lands between the two bytes of a pair, or in the same cycle as the second byte. If the pairing state is not cleared properly, a later byte is paired with a stale first byte and goes to the wrong register. The stimulus sends a lone first byte, then raises abort, then sends a full pair to a neighbouring address. It also sends a second byte while abort is high. After each of these, the bench checks that the abandoned target is untouched, that the strobe queue saw only the intended addresses, and that the following pair lands correctly.

// File: rtl/scrf_pkg.sv
package scrf_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 9;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              wrEn;     // store data at addr
    logic              swReset;  // reload every default
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ctlCmd_t;

  function automatic logic [DATA_W-1:0] regDefault(input int idx);
    logic [DATA_W-1:0] val;
    val = '0;
    if (idx == 0)                      val = 9'h121;
    else if (idx == 7)                 val = 9'h194;
    else if (idx >= 20 && idx <= 25)   val = 9'h0FF;
    else if (idx == 50)                val = 9'h05E;
    else if (idx == 51)                val = 9'h03E;
    return val;
  endfunction
endpackage

// File: rtl/scrf_ctrl.sv
module scrf_ctrl
  import scrf_pkg::*;
#(
  parameter int NUM_REGS = 54
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              frameAbort,
  output ctlCmd_t           cmd
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic              phase;   // 1: first byte held
  logic [BYTE_W-1:0] hiByte;
  logic              pairDone;
  logic [ADDR_W-1:0] pairAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= 1'b0;
      hiByte <= '0;
    end else if (frameAbort) begin
      phase  <= 1'b0;
    end else if (byteValid) begin
      if (!phase) begin
        hiByte <= byteData;
        phase  <= 1'b1;
      end else begin
        phase  <= 1'b0;
      end
    end
  end

  always_comb begin
    pairDone    = byteValid && phase && !frameAbort;
    pairAddr    = hiByte[BYTE_W-1:1];
    cmd.addr    = pairAddr;
    cmd.data    = {hiByte[0], byteData};
    cmd.wrEn    = pairDone && (pairAddr < LAST_ADDR);
    cmd.swReset = pairDone && (pairAddr == LAST_ADDR);
  end

  // R6: abort always leaves the pairing state empty
  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rstN)
    frameAbort |=> !phase);

  // R7: a first byte is held across idle cycles
  a_r7_first_held: assert property (@(posedge clk) disable iff (!rstN)
    (phase && !byteValid && !frameAbort) |=> (phase && $stable(hiByte)));

  // R3: restore and write commands are exclusive
  a_r3_cmd_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.wrEn && cmd.swReset));
endmodule

// File: rtl/scrf_regs.sv
module scrf_regs
  import scrf_pkg::*;
#(
  parameter int NUM_REGS = 54
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlCmd_t                      cmd,
  output logic [NUM_REGS*DATA_W-1:0]   regFlat,
  output logic                         wrStrobe,
  output logic [ADDR_W-1:0]            wrAddr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic [DATA_W-1:0] regQ [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam logic [DATA_W-1:0] DEF = regDefault(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regQ[g] <= DEF;
      else if (cmd.swReset)
        regQ[g] <= DEF;
      else if (cmd.wrEn && (cmd.addr == ADDR_W'(g)))
        regQ[g] <= cmd.data;
    end
    assign regFlat[g*DATA_W +: DATA_W] = regQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
    end else begin
      wrStrobe <= cmd.wrEn || cmd.swReset;
      if (cmd.wrEn || cmd.swReset) wrAddr <= cmd.addr;
    end
  end

  // R3: a strobe never lasts two cycles (a pair needs two byte cycles)
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R4: reported addresses stay inside the map
  a_r4_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (wrAddr <= LAST_ADDR));

  // R8: without a command the bank holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.wrEn || cmd.swReset) |=> $stable(regFlat));

  // R5: after a restore strobe, register 0 carries its default
  a_r5_restore_seen: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrAddr == LAST_ADDR) |-> (regQ[0] == regDefault(0)));
endmodule

// File: rtl/scrf_top.sv
module scrf_top
  import scrf_pkg::*;
#(
  parameter int NUM_REGS = 54
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       byteValid,
  input  logic [7:0]                 byteData,
  input  logic                       frameAbort,
  output logic [NUM_REGS*9-1:0]      regFlat,
  output logic                       wrStrobe,
  output logic [6:0]                 wrAddr
);
  ctlCmd_t cmd;

  scrf_ctrl #(.NUM_REGS(NUM_REGS)) uCtrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .frameAbort(frameAbort), .cmd(cmd)
  );

  scrf_regs #(.NUM_REGS(NUM_REGS)) uRegs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .regFlat(regFlat),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr)
  );
endmodule

// File: tb/tb_scrf_top.sv
module tb_scrf_top;
  localparam int N = 54;
  localparam int W = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic frameAbort = 1'b0;
  logic [N*W-1:0] regFlat;
  logic wrStrobe;
  logic [6:0] wrAddr;

  int checks = 0;
  int failures = 0;
  logic [8:0] model [N];
  logic [6:0] expQ [$];

  always #10 clk = ~clk;

  scrf_top dut (.clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
                .frameAbort(frameAbort), .regFlat(regFlat), .wrStrobe(wrStrobe),
                .wrAddr(wrAddr));

  function automatic logic [8:0] expDefault(int a);
    case (a)
      0: return 9'h121;
      7: return 9'h194;
      'h32: return 9'h05E;
      'h33: return 9'h03E;
      default: return (a >= 'h14 && a <= 'h19) ? 9'h0FF : 9'h000;
    endcase
  endfunction

  task automatic loadDefaults();
    for (int i = 0; i < N; i++) model[i] = expDefault(i);
  endtask

  task automatic checkAll(string tag);
    for (int i = 0; i < N; i++) begin
      checks++;
      if (regFlat[i*W +: W] !== model[i]) begin
        failures++;
        $display("FAIL %s reg 0x%02h actual=0x%03h expected=0x%03h", tag, i,
                 regFlat[i*W +: W], model[i]);
      end
    end
  endtask

  // monitor: compare every strobe against the scoreboard queue (R3)
  always @(negedge clk) begin
    if (rstN && wrStrobe) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R3 unexpected strobe actual=0x%02h expected=none", wrAddr);
      end else begin
        logic [6:0] e;
        e = expQ.pop_front();
        if (wrAddr !== e) begin
          failures++;
          $display("FAIL R3 strobe addr actual=0x%02h expected=0x%02h", wrAddr, e);
        end
      end
    end
  end

  task automatic sendByte(logic [7:0] b, logic abortNow);
    byteValid = 1'b1; byteData = b; frameAbort = abortNow;
    @(negedge clk);
    byteValid = 1'b0; frameAbort = 1'b0;
  endtask

  task automatic writePair(logic [6:0] a, logic [8:0] d, int gap);
    if (a <= 7'h35) expQ.push_back(a);
    sendByte({a, d[8]}, 1'b0);
    repeat (gap) @(negedge clk);
    sendByte(d[7:0], 1'b0);
    if (a == 7'h35) loadDefaults();
    else if (a < 7'h35) model[a] = d;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    loadDefaults();
    repeat (3) @(negedge clk);
    checkAll("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release");

    writePair(7'h00, 9'h1AB, 0);          // R2 bit 8 path
    checkAll("R2 write 0x00");
    writePair(7'h14, 9'h055, 4);          // R7 gap between bytes
    repeat (3) @(negedge clk);
    checkAll("R7 gapped write");
    writePair(7'h34, 9'h100, 0);          // R8 only the target moves
    writePair(7'h07, 9'h0C3, 1);
    checkAll("R8 isolated writes");

    writePair(7'h36, 9'h1FF, 0);          // R4 out of map
    writePair(7'h7F, 9'h0AA, 0);
    repeat (2) @(negedge clk);
    checkAll("R4 out of range");

    sendByte({7'h10, 1'b1}, 1'b0);        // R6 lone first byte then abort
    frameAbort = 1'b1; @(negedge clk); frameAbort = 1'b0;
    writePair(7'h11, 9'h0AA, 0);
    checkAll("R6 abort between bytes");
    sendByte({7'h12, 1'b1}, 1'b0);        // R6 abort with second byte
    sendByte(8'h77, 1'b1);
    writePair(7'h13, 9'h1E1, 0);
    checkAll("R6 abort on second byte");

    writePair(7'h35, 9'h1FF, 0);          // R5 restore, data ignored
    checkAll("R5 software restore");

    writePair(7'h20, 9'h123, 0);          // R1 async reset mid-run
    #3 rstN = 1'b0;
    loadDefaults();
    @(negedge clk);
    checkAll("R1 async reset");
    rstN = 1'b1;
    @(negedge clk);

    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R3 missing strobes actual=%0d expected=0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule